// File: doc/BRIEF.md
# Masked Multi-Field Time Alarm Comparator

This block watches the running calendar time of a real-time clock and raises an alarm when the time reaches a programmed moment. Five alarm registers hold BCD compare values for seconds, minutes, hours, day of month and weekday. Each register has its own exclude bit, so software can arm any subset of the fields. A field whose exclude bit is set plays no part in the comparison. The block checks the comparison once per second tick. When every armed field equals the current time, it sets a sticky alarm flag.

A control register holds the flag and an interrupt enable. The flag stays set until software writes a zero to it. The open-drain style interrupt output is active low. It is asserted for as long as both the flag and the enable are set. The time counters themselves live outside this block: it receives their values and the tick that marks each second boundary. Software reaches the alarm bank and the control bits through a single-cycle register port.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, all five alarm registers read 0x80, with every field excluded. The control register reads 0x00, and irq_n is 1.
- R2: The alarm registers sit at addresses 0x0B (seconds), 0x0C (minutes), 0x0D (hours), 0x0E (day of month) and 0x0F (weekday). A write stores all 8 bits, and a read returns them combinationally. The control register sits at 0x01 and reads {enable, flag, 6'b0}. Every other address reads 0x00.
- R3: Bit 7 of an alarm register set to 1 excludes that field from the match. The compared bits are bits 6:0 for seconds and minutes, bits 5:0 for hours and day, and bits 2:0 for weekday. Higher bits are ignored.
- R4: The flag is set at the clock edge that ends a cycle in which sec_tick is 1 and every non-excluded field equals the current time. Without sec_tick, a matching time does not set the flag.
- R5: When all five fields are excluded, the flag is never set.
- R6: A write to 0x01 with bit 6 at 0 clears the flag. A write with bit 6 at 1 leaves the flag unchanged, so software cannot set it.
- R7: irq_n is 0 exactly while the flag and the enable (bit 7 of 0x01) are both 1. The flag is set regardless of the enable.
- R8: When a match tick and a flag-clearing write fall in the same cycle, the flag ends up set.
- R9: When a write to an alarm register falls in the same cycle as a tick, the compare uses the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sec_tick | input | 1 | One-cycle pulse at each second boundary, time already updated |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_mday | input | 6 | Current day of month, BCD |
| now_wday | input | 3 | Current weekday |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
Two pairs of events can land in the same cycle. A matching second tick can coincide with a software write that clears the flag. A tick can also coincide with a write that reprograms an alarm field. The bench provokes each pair by driving the write strobe and the tick on the same falling edge. It then reads the control register afterwards. It expects the flag to be set in the first case. In the second case it expects the result to follow the old field value, and a later tick to follow the new one.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int FLD_W = 8;
  localparam int EXCL_BIT = 7;
  localparam int FLAG_BIT = 6;
  localparam int IEN_BIT = 7;

  typedef logic [NUM_FIELDS-1:0][FLD_W-1:0] field_bank_t;

  // compared bits per field: sec, min, hour, mday, wday
  function automatic logic [FLD_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction

  // field agrees when it is excluded or its compared bits are equal
  function automatic logic field_agrees(input logic [FLD_W-1:0] alarm_val,
                                        input logic [FLD_W-1:0] now_val,
                                        input logic [FLD_W-1:0] mask);
    return alarm_val[EXCL_BIT] || ((alarm_val & mask) == (now_val & mask));
  endfunction

  // next value of the sticky flag; a hit outranks a clearing write
  function automatic logic flag_next(input logic cur, input logic hit,
                                     input logic ctrl_wr, input logic wbit);
    if (hit) return 1'b1;
    if (ctrl_wr && !wbit) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/alarm_regbank.sv
module alarm_regbank
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int ALARM_BASE = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FLD_W-1:0]  wdata,
  output field_bank_t       bank,
  output logic              addr_hit,
  output logic [FLD_W-1:0]  rd_val
);
  logic [NUM_FIELDS-1:0] sel;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    assign sel[i] = (addr == ADDR_W'(ALARM_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[i] <= FLD_W'(1) << EXCL_BIT;
      else if (wr && sel[i])
        bank[i] <= wdata;
    end
  end

  assign addr_hit = |sel;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (sel[i]) rd_val = bank[i];
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_pkg::*;
(
  input  field_bank_t           bank,
  input  field_bank_t           now_vals,
  input  logic                  tick,
  output logic [NUM_FIELDS-1:0] field_ok,
  output logic                  any_armed,
  output logic                  hit
);
  logic [NUM_FIELDS-1:0] armed;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    assign armed[i]    = !bank[i][EXCL_BIT];
    assign field_ok[i] = field_agrees(bank[i], now_vals[i], field_mask(i));
  end

  assign any_armed = |armed;
  assign hit       = tick && any_armed && (&field_ok);
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [FLD_W-1:0] wdata,
  input  logic             hit,
  output logic             flag,
  output logic             ien,
  output logic [FLD_W-1:0] ctrl_val,
  output logic             irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ien  <= 1'b0;
    end else begin
      flag <= flag_next(flag, hit, ctrl_wr, wdata[FLAG_BIT]);
      if (ctrl_wr) ien <= wdata[IEN_BIT];
    end
  end

  always_comb begin
    ctrl_val = '0;
    ctrl_val[FLAG_BIT] = flag;
    ctrl_val[IEN_BIT]  = ien;
  end

  assign irq_n = !(flag && ien);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CTRL_ADDR = 1,
  parameter int ALARM_BASE = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              sec_tick,
  input  logic [6:0]        now_sec,
  input  logic [6:0]        now_min,
  input  logic [5:0]        now_hour,
  input  logic [5:0]        now_mday,
  input  logic [2:0]        now_wday,
  output logic              irq_n
);
  field_bank_t           bank;
  field_bank_t           now_vals;
  logic                  bank_sel;
  logic [FLD_W-1:0]      bank_rd;
  logic [FLD_W-1:0]      ctrl_rd;
  logic [NUM_FIELDS-1:0] field_ok;
  logic                  any_armed;
  logic                  match_hit;
  logic                  alarm_flag;
  logic                  irq_en;
  logic                  ctrl_sel;

  assign now_vals[0] = FLD_W'(now_sec);
  assign now_vals[1] = FLD_W'(now_min);
  assign now_vals[2] = FLD_W'(now_hour);
  assign now_vals[3] = FLD_W'(now_mday);
  assign now_vals[4] = FLD_W'(now_wday);

  assign ctrl_sel = (reg_addr == ADDR_W'(CTRL_ADDR));

  alarm_regbank #(.ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .bank(bank), .addr_hit(bank_sel), .rd_val(bank_rd)
  );

  alarm_compare u_cmp (
    .bank(bank), .now_vals(now_vals), .tick(sec_tick),
    .field_ok(field_ok), .any_armed(any_armed), .hit(match_hit)
  );

  alarm_flag_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(reg_wr && ctrl_sel), .wdata(reg_wdata),
    .hit(match_hit), .flag(alarm_flag), .ien(irq_en), .ctrl_val(ctrl_rd),
    .irq_n(irq_n)
  );

  always_comb begin
    if (ctrl_sel)      reg_rdata = ctrl_rd;
    else if (bank_sel) reg_rdata = bank_rd;
    else               reg_rdata = '0;
  end
endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker #(
  parameter int ADDR_W = 5,
  parameter int CTRL_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              sec_tick,
  input logic              irq_n,
  input logic              match_hit,
  input logic              alarm_flag,
  input logic              irq_en,
  input logic              any_armed
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR)) && !reg_wdata[6];

  p_hit_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> alarm_flag);
  p_hit_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> sec_tick);
  p_none_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_armed |-> !match_hit);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_wr) |=> alarm_flag);
  p_flag_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !match_hit) |=> !alarm_flag);
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n);
  p_irq_follows_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_flag |-> irq_n);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && clr_wr) |=> alarm_flag);
endmodule

bind alarm_match_unit alarm_match_checker #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sec_tick(sec_tick), .irq_n(irq_n),
  .match_hit(match_hit), .alarm_flag(alarm_flag), .irq_en(irq_en),
  .any_armed(any_armed)
);

// File: tb/tb_alarm_match_unit.sv
module tb_alarm_match_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h01;
  localparam logic [4:0] A_SEC = 5'h0B, A_MIN = 5'h0C, A_HOUR = 5'h0D,
                         A_MDAY = 5'h0E, A_WDAY = 5'h0F;

  logic clk = 0, rst_n = 0, reg_wr = 0, sec_tick = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [6:0] now_sec = 0, now_min = 0;
  logic [5:0] now_hour = 0, now_mday = 0;
  logic [2:0] now_wday = 0;
  logic irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_unit dut (.*);

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_time(input int s, input int m, input int h, input int md, input int wd);
    now_sec = 7'(to_bcd(s)); now_min = 7'(to_bcd(m));
    now_hour = 6'(to_bcd(h)); now_mday = 6'(to_bcd(md)); now_wday = 3'(wd);
  endtask

  task automatic tick(input int s, input int m, input int h, input int md, input int wd);
    @(negedge clk); set_time(s, m, h, md, wd); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic flag_of(output logic f);
    logic [7:0] v; rd(A_CTRL, v); f = v[6];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic f;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 11; a <= 15; a++) begin rd(5'(a), v); check("R1", v, 8'h80); end
    rd(A_CTRL, v); check("R1", v, 8'h00);
    check("R1", {7'd0, irq_n}, 8'h01);

    // R2 readback and unmapped addresses
    wr(A_HOUR, 8'hA5); rd(A_HOUR, v); check("R2", v, 8'hA5);
    rd(5'h05, v); check("R2", v, 8'h00);
    wr(A_HOUR, 8'h80);

    // R5 all excluded: ticks never set flag
    for (int s = 0; s < 60; s += 7) begin
      tick(s, 0, 0, 1, 0); flag_of(f); check("R5", {7'd0, f}, 8'h00);
    end

    // R3/R4 seconds-only sweep; other fields vary and must be ignored
    wr(A_SEC, 8'h25);
    for (int s = 0; s < 60; s++) begin
      tick(s, s, s % 24, 1 + s % 28, s % 7); flag_of(f);
      check("R4", {7'd0, f}, (s == 25) ? 8'h01 : 8'h00);
      if (f) wr(A_CTRL, 8'h00);
    end

    // R4 match without tick does not set
    @(negedge clk); set_time(25, 0, 0, 1, 0); repeat (3) @(negedge clk);
    flag_of(f); check("R4", {7'd0, f}, 8'h00);

    // R3 hour+day sweep, seconds excluded again; upper bits of register ignored
    wr(A_SEC, 8'h80); wr(A_HOUR, 8'h57 & 8'h7F | 8'h40); wr(A_MDAY, 8'h41 | 8'h00);
    // hour compares bits 5:0 of 0x57 -> 0x17; mday 0x41 -> 0x01
    for (int h = 0; h < 24; h++) begin
      tick(3, 4, h, 1, 2); flag_of(f);
      check("R3", {7'd0, f}, (h == 17) ? 8'h01 : 8'h00);
      if (f) wr(A_CTRL, 8'h00);
    end
    tick(3, 4, 17, 2, 2); flag_of(f); check("R3", {7'd0, f}, 8'h00);
    wr(A_HOUR, 8'h80); wr(A_MDAY, 8'h80);

    // R3 weekday-only sweep
    wr(A_WDAY, 8'h05);
    for (int w = 0; w < 8; w++) begin
      tick(0, 0, 0, 1, w); flag_of(f);
      check("R3", {7'd0, f}, (w == 5) ? 8'h01 : 8'h00);
      if (f) wr(A_CTRL, 8'h00);
    end

    // R7 flag sets while enable is 0, irq stays high
    tick(0, 0, 0, 1, 5); flag_of(f);
    check("R7", {7'd0, f}, 8'h01); check("R7", {7'd0, irq_n}, 8'h01);
    wr(A_CTRL, 8'hC0); check("R7", {7'd0, irq_n}, 8'h00);
    rd(A_CTRL, v); check("R2", v, 8'hC0);
    // R6 clear by writing 0, enable kept
    wr(A_CTRL, 8'h80); rd(A_CTRL, v); check("R6", v, 8'h80);
    check("R7", {7'd0, irq_n}, 8'h01);
    // R6 writing 1 cannot set flag
    wr(A_CTRL, 8'hC0); rd(A_CTRL, v); check("R6", v, 8'h80);
    check("R6", {7'd0, irq_n}, 8'h01);

    // R8 match tick and clearing write in the same cycle
    @(negedge clk); set_time(0, 0, 0, 1, 5); sec_tick = 1;
    reg_wr = 1; reg_addr = A_CTRL; reg_wdata = 8'h80;
    @(negedge clk); sec_tick = 0; reg_wr = 0;
    flag_of(f); check("R8", {7'd0, f}, 8'h01);
    check("R8", {7'd0, irq_n}, 8'h00);
    wr(A_CTRL, 8'h00);

    // R9 register write coinciding with tick uses old value
    @(negedge clk); set_time(0, 0, 0, 1, 3); sec_tick = 1;
    reg_wr = 1; reg_addr = A_WDAY; reg_wdata = 8'h03;
    @(negedge clk); sec_tick = 0; reg_wr = 0;
    flag_of(f); check("R9", {7'd0, f}, 8'h00);
    tick(0, 0, 0, 1, 3); flag_of(f); check("R9", {7'd0, f}, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule